// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter that software must restart at regular intervals. A programmable preload value is loaded into a down-counter. The counter decrements on a prescaled tick. If it reaches zero before software restarts it, the block takes the actions that are enabled in its control register. It can raise a level interrupt, drive an active-low pulse on an external overflow pin, or hold a system reset request high for a fixed number of cycles.

Every write must carry an 8-bit key in the top byte of the data word. A write with the wrong key changes nothing and sets a sticky error flag. The control register accepts only one keyed write after reset, so a runaway program cannot later switch the watchdog off or weaken it. After reset the watchdog is already running with the largest preload, and the pin and reset actions are enabled.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `ovf_n` is high, `irq` and `rst_req` are low, and status reads 0. Control reads 0x0D: run at bit 0, pin enable at bit 2, reset enable at bit 3, select 0, lock bit 6 clear. Preload reads all ones.
- R2: A write is accepted only when `wr_data[31:24]` equals the key (0xA5). A write with any other key changes no register and sets the sticky key-error bit, status bit 1.
- R3: A keyed write to address 2 (restart) loads the counter from the preload register, address 1, and restarts the prescaler. A restart write with a bad key leaves the count running undisturbed.
- R4: Control bits [5:4] select the tick divisor: 0→1, 1→8, 2→64, 3→256. After a restart write at edge E with preload P and divisor D, the first overflow action appears at edge E+P·D+1.
- R5: When the counter reaches zero while running, status bit 0 (overflow) sets. It stays set until a keyed write to address 3 with data bit 0 set. Bit 1 of that write clears the key-error bit.
- R6: `irq` is high while the overflow bit is set and control bit 1 (interrupt enable) is set.
- R7: With control bit 2 set, each expiry drives `ovf_n` low for exactly 16 cycles.
- R8: With control bit 3 set, each expiry drives `rst_req` high for exactly 16 cycles.
- R9: The actions fire once per expiry. The counter then rests at zero and nothing repeats until the next restart.
- R10: The first keyed write to control (address 0) after reset is taken and sets lock bit 6. Later keyed control writes are ignored and do not set the key error.
- R11: With control bit 0 (run) clear, the counter holds its value and no action fires.
- R12: A keyed restart sampled in the same cycle the expiry would fire wins: no action fires and the overflow bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 preload, 2 restart, 3 status clear |
| wr_data | input | 32 | Write data, key in bits 31:24 |
| rd_addr | input | 2 | Read address: 0 control, 1 preload, 2 count, 3 status |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Overflow interrupt, level |
| ovf_n | output | 1 | External overflow pulse, active low |
| rst_req | output | 1 | System reset request pulse |

## Verification
Two functions can fall on the same clock edge: a keyed restart and the expiry of the counter. The bench lets a countdown run down to zero. It then issues a restart that is sampled exactly on the expiry edge, and expects no pin pulse and a clear overflow bit. It repeats the run with the restart one edge late, and expects one pulse and the overflow bit set, followed by a new countdown. A scoreboard holds the predicted edge of every pin pulse, so any extra, missing or mistimed pulse is reported.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          CW    = 16,
  parameter logic [7:0]  KEY   = 8'hA5,
  parameter int          PULSE = 16,
  localparam int         PW    = $clog2(PULSE + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        ovf_n,
  output logic        rst_req
);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [5:0]    CRST  = 6'b001101;
  localparam logic [PW-1:0] PLOAD = PW'(PULSE);

  logic [5:0]    ctrl;
  logic          lock;
  logic [CW-1:0] preload, cnt;
  logic [7:0]    presc, mask;
  logic          fired, ovf, kerr;
  logic [PW-1:0] pin_cnt, rst_cnt;

  wire key_ok  = wr_data[31:24] == KEY;
  wire wr_good = wr_en & key_ok;
  wire wr_bad  = wr_en & ~key_ok;
  wire do_ctrl = wr_good & (wr_addr == 2'd0) & ~lock;
  wire do_pre  = wr_good & (wr_addr == 2'd1);
  wire kick    = wr_good & (wr_addr == 2'd2);
  wire do_clr  = wr_good & (wr_addr == 2'd3);

  wire run    = ctrl[0];
  wire irq_en = ctrl[1];
  wire pin_en = ctrl[2];
  wire rst_en = ctrl[3];

  always_comb begin
    case (ctrl[5:4])
      2'd0:    mask = 8'h00;
      2'd1:    mask = 8'h07;
      2'd2:    mask = 8'h3F;
      default: mask = 8'hFF;
    endcase
  end

  wire tick = (presc & mask) == mask;
  wire fire = run & (cnt == '0) & ~fired & ~kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CRST;
      lock <= 1'b0;
    end else if (do_ctrl) begin
      ctrl <= wr_data[5:0];
      lock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preload <= CMAX;
    else if (do_pre) preload <= wr_data[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= CMAX;
      fired <= 1'b0;
    end else begin
      presc <= kick ? '0 : presc + 8'd1;
      if (kick)
        cnt <= preload;
      else if (run && tick && cnt != '0)
        cnt <= cnt - 1'b1;
      if (kick)      fired <= 1'b0;
      else if (fire) fired <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf  <= 1'b0;
      kerr <= 1'b0;
    end else begin
      if (fire)                    ovf <= 1'b1;
      else if (do_clr && wr_data[0]) ovf <= 1'b0;
      if (wr_bad)                  kerr <= 1'b1;
      else if (do_clr && wr_data[1]) kerr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_cnt <= '0;
      rst_cnt <= '0;
    end else begin
      if (fire && pin_en)      pin_cnt <= PLOAD;
      else if (pin_cnt != '0)  pin_cnt <= pin_cnt - 1'b1;
      if (fire && rst_en)      rst_cnt <= PLOAD;
      else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign ovf_n   = pin_cnt == '0;
  assign rst_req = rst_cnt != '0;
  assign irq     = ovf & irq_en;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {25'd0, lock, ctrl};
      2'd1:    rd_data = 32'(preload);
      2'd2:    rd_data = 32'(cnt);
      default: rd_data = {30'd0, kerr, ovf};
    endcase
  end
endmodule

module keyed_wdt_sva #(
  parameter int         CW  = 16,
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [31:0]   wr_data,
  input logic [5:0]    ctrl,
  input logic          lock,
  input logic [CW-1:0] cnt,
  input logic          fired,
  input logic          ovf,
  input logic          kerr,
  input logic          ovf_n,
  input logic          rst_req
);
  wire keyed = wr_en && wr_data[31:24] == KEY;
  wire kick  = keyed && wr_addr == 2'd2;
  wire clr   = keyed && wr_addr == 2'd3;

  AST_BADKEY_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !keyed) |=> $stable(ctrl)); // R2
  AST_KEYERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (kerr && !(clr && wr_data[1])) |=> kerr); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(clr && wr_data[0])) |=> ovf); // R5
  AST_PIN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_n) |-> (cnt == '0 && fired)); // R7
  AST_RST_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> fired); // R8
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !kick) |=> fired); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(ctrl) && lock)); // R10
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !kick) |=> $stable(cnt)); // R11
  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && cnt == '0 && ctrl[0] && !fired) |=> (!fired && $stable(ovf_n))); // R12
endmodule

bind keyed_wdt keyed_wdt_sva #(.CW(CW), .KEY(KEY)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl(ctrl), .lock(lock), .cnt(cnt), .fired(fired), .ovf(ovf), .kerr(kerr),
  .ovf_n(ovf_n), .rst_req(rst_req)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
  localparam logic [31:0] K  = 32'hA500_0000;
  localparam logic [31:0] BK = 32'h5A00_0000;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        irq, ovf_n, rst_req;

  int tests = 0, fails = 0, cyc = 0;
  int exp_q[$];
  bit done = 0;

  keyed_wdt u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
                .irq, .ovf_n, .rst_req);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int stamp);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    stamp = cyc;
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pulse timing against the scoreboard, pulse widths
  bit prev_pin = 1, prev_rst = 0;
  int pin_w = 0, rst_w = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_pin && !ovf_n) begin
        if (exp_q.size() == 0) chk("R9 unexpected pulse", cyc, 0);
        else chk("R4 pulse edge", cyc, exp_q.pop_front());
      end
      if (!ovf_n) pin_w++;
      if (!prev_pin && ovf_n) begin chk("R7 pin width", pin_w, 16); pin_w = 0; end
      if (rst_req) rst_w++;
      if (prev_rst && !rst_req) begin chk("R8 reset width", rst_w, 16); rst_w = 0; end
    end
    prev_pin = ovf_n;
    prev_rst = rst_req;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s, s2;
    do_reset();
    // R1
    chk("R1 ovf_n", ovf_n, 1); chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);
    rd(0, v); chk("R1 ctrl", v, 32'h0D);
    rd(1, v); chk("R1 preload", v, 32'hFFFF);
    rd(3, v); chk("R1 status", v, 0);
    // R2
    wr(0, BK | 32'h00, s); rd(0, v); chk("R2 bad ctrl ignored", v, 32'h0D);
    rd(3, v); chk("R2 key error set", v, 2);
    wr(1, BK | 32'd7, s); rd(1, v); chk("R2 bad preload ignored", v, 32'hFFFF);
    wr(3, K | 32'd2, s); rd(3, v); chk("R5 clear key error", v, 0);
    // R10
    wr(1, K | 32'd10, s);
    wr(0, K | 32'h0F, s); rd(0, v); chk("R10 first ctrl write", v, 32'h4F);
    wr(0, K | 32'h00, s); rd(0, v); chk("R10 locked ctrl", v, 32'h4F);
    rd(3, v); chk("R10 no key error", v, 0);
    // R3
    wr(2, K, s); exp_q.push_back(s + 11);
    rd(2, v); chk("R3 reload", v, 10);
    waitn(3);
    wr(2, BK, s2); rd(2, v); chk("R3 bad restart no reload", v, 6);
    waitn(7);
    chk("R6 irq", irq, 1); chk("R8 reset req", rst_req, 1);
    rd(3, v); chk("R5 ovf set", v, 3);
    waitn(60);
    rd(2, v); chk("R9 rest at zero", v, 0);
    wr(3, K | 32'd1, s); chk("R6 irq cleared", irq, 0);
    rd(3, v); chk("R5 ovf cleared", v, 2);
    wr(3, K | 32'd2, s);
    // R12
    wr(1, K | 32'd20, s);
    wr(2, K, s); waitn(20);
    wr(2, K, s2); rd(3, v); chk("R12 restart wins", v, 0);
    chk("R12 pin idle", ovf_n, 1);
    exp_q.push_back(s2 + 21); waitn(30);
    rd(3, v); chk("R12 later expiry", v, 1);
    wr(2, K, s); exp_q.push_back(s + 21); waitn(21);
    wr(2, K, s2); exp_q.push_back(s2 + 21);
    rd(2, v); chk("R12 late restart reloads", v, 20);
    waitn(50);
    // R4 divisors
    do_reset();
    wr(1, K | 32'd5, s); wr(0, K | 32'h1D, s);
    wr(2, K, s); exp_q.push_back(s + 41); waitn(70);
    do_reset();
    wr(1, K | 32'd3, s); wr(0, K | 32'h2D, s);
    wr(2, K, s); exp_q.push_back(s + 193); waitn(220);
    do_reset();
    wr(1, K | 32'd2, s); wr(0, K | 32'h3D, s);
    wr(2, K, s); exp_q.push_back(s + 513); waitn(540);
    chk("R4 all pulses seen", exp_q.size(), 0);
    // R11
    do_reset();
    wr(1, K | 32'd5, s); wr(0, K | 32'h0C, s);
    wr(2, K, s); waitn(30);
    rd(2, v); chk("R11 count frozen", v, 5);
    chk("R11 pin idle", ovf_n, 1);
    rd(3, v); chk("R11 no overflow", v, 0);
    chk("R9 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule